// File: doc/BRIEF.md
# Stereo Limiter Gain Controller

This block sits beside the shared volume stage of a stereo digital audio path and pulls the volume down when the signal gets too loud. On every sample strobe it looks at the left and right samples taken after the gain stage. The samples use a signed word with headroom above digital full scale (FS). The block takes the larger of the two magnitudes and compares it with one of four selectable detection levels. When the level is too high, it lowers one shared target volume code. The size of the step depends on a step-mode select and on how far the peak lies above FS.

The target can reach the two channel volume codes in two ways. The first is at once, on the same strobe. The second is per channel, when that channel's sample changes sign or when a selectable timeout runs out. A small state machine with two states keeps at most one zero-cross-gated target in flight. In LS_IDLE, an over-threshold strobe either applies the new target at once (transition IDLE→IDLE, "force") or latches it for gated application (transition IDLE→PEND, "latch"). In LS_PEND, a strobe that is above FS or arrives with zero-cross gating off forces the new value and returns to idle (PEND→IDLE, "force"). A strobe on which both channels have taken the target also returns to idle (PEND→IDLE, "settle"). Other over-threshold strobes are ignored while in LS_PEND (PEND→PEND, "wait").

Top module: `stereo_lim_gain`

## Requirements
- R1: After reset both volume codes equal VOL_INIT (default 160), and the volume codes never change on a clock in which `smp_vld` is low.
- R2: While `lim_en` is 0, no new attenuation is started, whatever the sample level.
- R3: The detected level is the larger of the two channel magnitudes. A magnitude is the absolute value of the signed 20-bit sample, with -524288 saturating to 524287. FS corresponds to 65536. A strobe is over threshold when the level is strictly greater than 49145, 40876, 32846 or 24631 for `thr_sel` = 0, 1, 2 or 3 respectively.
- R4: An over-threshold level on either channel attenuates both channels toward one shared target code.
- R5: Overshoot band: 0 if the level is below 65536; 1 if from 65536 to 131071; 2 if from 131072 to 262143; 3 if 262144 or more. The step for bands 0..3 is 1,1,1,1 for `step_sel`=0; 2,2,2,2 for `step_sel`=1; 2,4,4,8 for `step_sel`=2; 1,2,8,8 for `step_sel`=3.
- R6: With `zc_off`=0 and an over-threshold level in band 0, the new target is latched and each channel's code takes it on the first later strobe where that channel's sign bit differs from its previous sample. Further band-0 over-threshold strobes are ignored until both channels have taken the target.
- R7: A latched target that sees no zero crossing reaches the channel on the strobe 128 << `tmo_sel` strobes after the latching strobe.
- R8: With `zc_off`=0 and a level of 65536 or more, both codes drop by the R5 step on that same strobe (visible after the strobe's clock edge).
- R9: With `zc_off`=1, every over-threshold strobe lowers both codes by exactly 1 at once, whatever `step_sel` is.
- R10: The volume codes saturate at 0 and never increase.
- R11: Once both channels have taken a gated target, the next over-threshold strobe starts a new attenuation from that target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe, one clock per sample period |
| smp_l | input | 20 | Left post-gain sample, signed |
| smp_r | input | 20 | Right post-gain sample, signed |
| lim_en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Detection level select |
| step_sel | input | 2 | Step mode select |
| zc_off | input | 1 | 1 = apply changes at once, step fixed at 1 |
| tmo_sel | input | 2 | Zero-cross timeout select |
| vol_l | output | 8 | Left volume code |
| vol_r | output | 8 | Right volume code |

## Verification
A wrong shared target shows up on both volume codes on the strobe edge for immediate updates. For gated updates it shows up no later than the timeout after the latching strobe. A stuck pending flag or a miscounted timeout makes one channel lag the other: the right code stays too high exactly one strobe beyond the timeout. A wrong state (staying pending, or leaving it too early) shows up at the next over-threshold strobe, as a missing or extra step on both codes.

// File: rtl/stereo_lim_pkg.sv
package stereo_lim_pkg;

    typedef enum logic [1:0] {
        BAND_NEAR = 2'd0,
        BAND_FS   = 2'd1,
        BAND_FS6  = 2'd2,
        BAND_FS12 = 2'd3
    } over_band_e;

    typedef enum logic {
        LS_IDLE = 1'b0,
        LS_PEND = 1'b1
    } lim_state_e;

    // detection level as a Q16 fraction of full scale
    function automatic logic [15:0] thr_frac(input logic [1:0] sel);
        logic [15:0] k;
        unique case (sel)
            2'd0: k = 16'd49145;
            2'd1: k = 16'd40876;
            2'd2: k = 16'd32846;
            default: k = 16'd24631;
        endcase
        return k;
    endfunction

    function automatic logic [3:0] step_amt(input logic [1:0] sel, input over_band_e b);
        logic [3:0] s;
        unique case (sel)
            2'd0: s = 4'd1;
            2'd1: s = 4'd2;
            2'd2: s = (b == BAND_NEAR) ? 4'd2 : ((b == BAND_FS12) ? 4'd8 : 4'd4);
            default: s = (b == BAND_NEAR) ? 4'd1 : ((b == BAND_FS) ? 4'd2 : 4'd8);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stereo_lim_level.sv
module stereo_lim_level
    import stereo_lim_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int FS_LOG2  = 16
) (
    input  logic [SAMPLE_W-1:0] smp_l,
    input  logic [SAMPLE_W-1:0] smp_r,
    input  logic [1:0]          thr_sel,
    output logic                over,
    output logic                above_fs,
    output over_band_e          band
);
    localparam int MAG_W  = SAMPLE_W - 1;
    localparam int PROD_W = 16 + FS_LOG2 + 1;
    localparam logic [SAMPLE_W-1:0] FS_LVL   = SAMPLE_W'(1) << FS_LOG2;
    localparam logic [SAMPLE_W-1:0] FS6_LVL  = SAMPLE_W'(1) << (FS_LOG2 + 1);
    localparam logic [SAMPLE_W-1:0] FS12_LVL = SAMPLE_W'(1) << (FS_LOG2 + 2);

    logic [1:0][SAMPLE_W-1:0] smp_pair;
    logic [1:0][SAMPLE_W-1:0] mag_pair;
    logic [SAMPLE_W-1:0]      peak;
    logic [SAMPLE_W-1:0]      thr_lvl;
    logic [PROD_W-1:0]        prod;

    assign smp_pair = {smp_r, smp_l};

    for (genvar c = 0; c < 2; c++) begin : g_mag
        logic [SAMPLE_W-1:0] neg;
        assign neg = ~smp_pair[c] + 1'b1;
        always_comb begin
            if (!smp_pair[c][SAMPLE_W-1]) begin
                mag_pair[c] = smp_pair[c];
            end else if (smp_pair[c] == {1'b1, {MAG_W{1'b0}}}) begin
                mag_pair[c] = {1'b0, {MAG_W{1'b1}}};
            end else begin
                mag_pair[c] = neg;
            end
        end
    end

    assign peak    = (mag_pair[0] > mag_pair[1]) ? mag_pair[0] : mag_pair[1];
    assign prod    = PROD_W'(thr_frac(thr_sel)) << FS_LOG2;
    assign thr_lvl = SAMPLE_W'(prod >> 16);

    always_comb begin
        if (peak >= FS12_LVL) begin
            band = BAND_FS12;
        end else if (peak >= FS6_LVL) begin
            band = BAND_FS6;
        end else if (peak >= FS_LVL) begin
            band = BAND_FS;
        end else begin
            band = BAND_NEAR;
        end
    end

    assign above_fs = (peak >= FS_LVL);
    assign over     = (peak > thr_lvl);

endmodule

// File: rtl/stereo_lim_ctrl.sv
module stereo_lim_ctrl
    import stereo_lim_pkg::*;
#(
    parameter int              VOL_W    = 8,
    parameter logic [VOL_W-1:0] VOL_INIT = 8'd160
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             lim_en,
    input  logic             over,
    input  logic             above_fs,
    input  over_band_e       band,
    input  logic [1:0]       step_sel,
    input  logic             zc_off,
    input  logic             chans_done,
    output logic [VOL_W-1:0] tgt_q,
    output logic [VOL_W-1:0] tgt_d,
    output logic             force_apply,
    output logic             latch_new
);
    lim_state_e      st_q, st_d;
    logic [3:0]      dec;
    logic [VOL_W-1:0] sub;
    logic            act;
    logic            immediate;

    assign dec       = zc_off ? 4'd1 : step_amt(step_sel, band);
    assign sub       = (tgt_q > VOL_W'(dec)) ? (tgt_q - VOL_W'(dec)) : '0;
    assign act       = smp_vld && lim_en && over;
    assign immediate = zc_off || above_fs;

    // state register and shared target
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LS_IDLE;
            tgt_q <= VOL_INIT;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_IDLE: begin
                if (act && !immediate) begin
                    st_d = LS_PEND;
                end
            end
            LS_PEND: begin
                if ((act && immediate) || (smp_vld && chans_done)) begin
                    st_d = LS_IDLE;
                end
            end
            default: st_d = LS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tgt_d       = tgt_q;
        force_apply = 1'b0;
        latch_new   = 1'b0;
        unique case (st_q)
            LS_IDLE: begin
                if (act) begin
                    tgt_d       = sub;
                    force_apply = immediate;
                    latch_new   = !immediate;
                end
            end
            LS_PEND: begin
                if (act && immediate) begin
                    tgt_d       = sub;
                    force_apply = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stereo_lim_chan.sv
module stereo_lim_chan #(
    parameter int               VOL_W      = 8,
    parameter logic [VOL_W-1:0] VOL_INIT   = 8'd160,
    parameter int               TMO_BASE_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             sgn,
    input  logic [1:0]       tmo_sel,
    input  logic             latch_new,
    input  logic             force_apply,
    input  logic [VOL_W-1:0] tgt_d,
    input  logic [VOL_W-1:0] tgt_q,
    output logic [VOL_W-1:0] vol,
    output logic             done
);
    localparam int CNT_W = TMO_BASE_LOG2 + 4;

    logic             pend_q;
    logic             sgn_prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_lim;
    logic             zc_hit;
    logic             apply_now;

    assign cnt_lim   = (CNT_W'(1) << (TMO_BASE_LOG2 + int'(tmo_sel))) - 1'b1;
    assign zc_hit    = (sgn != sgn_prev_q);
    assign apply_now = pend_q && smp_vld && (zc_hit || (cnt_q == cnt_lim));
    assign done      = !pend_q || apply_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol        <= VOL_INIT;
            pend_q     <= 1'b0;
            cnt_q      <= '0;
            sgn_prev_q <= 1'b0;
        end else begin
            if (smp_vld) begin
                sgn_prev_q <= sgn;
            end
            if (force_apply) begin
                vol    <= tgt_d;
                pend_q <= 1'b0;
            end else if (latch_new) begin
                pend_q <= 1'b1;
                cnt_q  <= '0;
            end else if (apply_now) begin
                vol    <= tgt_q;
                pend_q <= 1'b0;
            end else if (pend_q && smp_vld) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stereo_lim_gain.sv
module stereo_lim_gain
    import stereo_lim_pkg::*;
#(
    parameter int               SAMPLE_W      = 20,
    parameter int               FS_LOG2       = 16,
    parameter int               VOL_W         = 8,
    parameter logic [VOL_W-1:0] VOL_INIT      = 8'd160,
    parameter int               TMO_BASE_LOG2 = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_l,
    input  logic [SAMPLE_W-1:0] smp_r,
    input  logic                lim_en,
    input  logic [1:0]          thr_sel,
    input  logic [1:0]          step_sel,
    input  logic                zc_off,
    input  logic [1:0]          tmo_sel,
    output logic [VOL_W-1:0]    vol_l,
    output logic [VOL_W-1:0]    vol_r
);
    logic             over;
    logic             above_fs;
    over_band_e       band;
    logic [VOL_W-1:0] tgt_q;
    logic [VOL_W-1:0] tgt_d;
    logic             force_apply;
    logic             latch_new;
    logic [1:0]       ch_done;
    logic [1:0]       ch_sgn;
    logic [1:0][VOL_W-1:0] ch_vol;

    stereo_lim_level #(
        .SAMPLE_W (SAMPLE_W),
        .FS_LOG2  (FS_LOG2)
    ) level_i (
        .smp_l    (smp_l),
        .smp_r    (smp_r),
        .thr_sel  (thr_sel),
        .over     (over),
        .above_fs (above_fs),
        .band     (band)
    );

    stereo_lim_ctrl #(
        .VOL_W    (VOL_W),
        .VOL_INIT (VOL_INIT)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .smp_vld     (smp_vld),
        .lim_en      (lim_en),
        .over        (over),
        .above_fs    (above_fs),
        .band        (band),
        .step_sel    (step_sel),
        .zc_off      (zc_off),
        .chans_done  (&ch_done),
        .tgt_q       (tgt_q),
        .tgt_d       (tgt_d),
        .force_apply (force_apply),
        .latch_new   (latch_new)
    );

    assign ch_sgn = {smp_r[SAMPLE_W-1], smp_l[SAMPLE_W-1]};

    for (genvar c = 0; c < 2; c++) begin : g_chan
        stereo_lim_chan #(
            .VOL_W         (VOL_W),
            .VOL_INIT      (VOL_INIT),
            .TMO_BASE_LOG2 (TMO_BASE_LOG2)
        ) chan_i (
            .clk         (clk),
            .rst         (rst),
            .smp_vld     (smp_vld),
            .sgn         (ch_sgn[c]),
            .tmo_sel     (tmo_sel),
            .latch_new   (latch_new),
            .force_apply (force_apply),
            .tgt_d       (tgt_d),
            .tgt_q       (tgt_q),
            .vol         (ch_vol[c]),
            .done        (ch_done[c])
        );
    end

    assign vol_l = ch_vol[0];
    assign vol_r = ch_vol[1];

endmodule

// File: rtl/stereo_lim_gain_chk.sv
module stereo_lim_gain_chk
    import stereo_lim_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int FS_LOG2  = 16,
    parameter int VOL_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_vld,
    input logic [SAMPLE_W-1:0] smp_l,
    input logic [SAMPLE_W-1:0] smp_r,
    input logic                lim_en,
    input logic [1:0]          thr_sel,
    input logic                zc_off,
    input logic [VOL_W-1:0]    vol_l,
    input logic [VOL_W-1:0]    vol_r
);
    function automatic logic [SAMPLE_W-1:0] abs_sat(input logic [SAMPLE_W-1:0] s);
        logic [SAMPLE_W-1:0] r;
        if (!s[SAMPLE_W-1]) r = s;
        else if (s == {1'b1, {(SAMPLE_W-1){1'b0}}}) r = {1'b0, {(SAMPLE_W-1){1'b1}}};
        else r = ~s + 1'b1;
        return r;
    endfunction

    logic [SAMPLE_W-1:0] pk;
    logic [SAMPLE_W-1:0] thr;
    logic [SAMPLE_W-1:0] a_l, a_r;

    assign a_l = abs_sat(smp_l);
    assign a_r = abs_sat(smp_r);
    assign pk  = (a_l > a_r) ? a_l : a_r;
    assign thr = SAMPLE_W'((64'(thr_frac(thr_sel)) << FS_LOG2) >> 16);

    a_r1_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(vol_l) && $stable(vol_r)));

    a_r10_never_rises: assert property (@(posedge clk) disable iff (rst)
        (vol_l <= $past(vol_l)) && (vol_r <= $past(vol_r)));

    a_r8_above_fs_both_at_once: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && lim_en && !zc_off && (pk >= (SAMPLE_W'(1) << FS_LOG2))) |=> (vol_l == vol_r));

    a_r9_zc_off_both_at_once: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && lim_en && zc_off && (pk > thr)) |=> (vol_l == vol_r));

endmodule

bind stereo_lim_gain stereo_lim_gain_chk #(
    .SAMPLE_W (SAMPLE_W),
    .FS_LOG2  (FS_LOG2),
    .VOL_W    (VOL_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_l    (smp_l),
    .smp_r    (smp_r),
    .lim_en   (lim_en),
    .thr_sel  (thr_sel),
    .zc_off   (zc_off),
    .vol_l    (vol_l),
    .vol_r    (vol_r)
);

// File: tb/stereo_lim_gain_tb_top.sv
module stereo_lim_gain_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [19:0] smp_l = '0;
    logic [19:0] smp_r = '0;
    logic        lim_en = 1'b1;
    logic [1:0]  thr_sel = 2'd0;
    logic [1:0]  step_sel = 2'd0;
    logic        zc_off = 1'b0;
    logic [1:0]  tmo_sel = 2'd0;
    logic [7:0]  vol_l;
    logic [7:0]  vol_r;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stereo_lim_gain dut_i (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp_l    (smp_l),
        .smp_r    (smp_r),
        .lim_en   (lim_en),
        .thr_sel  (thr_sel),
        .step_sel (step_sel),
        .zc_off   (zc_off),
        .tmo_sel  (tmo_sel),
        .vol_l    (vol_l),
        .vol_r    (vol_r)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        smp_l = '0;
        smp_r = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input int l, input int r);
        @(negedge clk);
        smp_l = 20'(l);
        smp_r = 20'(r);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    function automatic int abs_sat(input int v);
        if (v == -524288) return 524287;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int band_of(input int m);
        if (m >= 262144) return 3;
        if (m >= 131072) return 2;
        if (m >= 65536) return 1;
        return 0;
    endfunction

    function automatic int step_of(input int ss, input int b);
        case (ss)
            0: return 1;
            1: return 2;
            2: return (b == 0) ? 2 : ((b == 3) ? 8 : 4);
            default: return (b == 0) ? 1 : ((b == 1) ? 2 : 8);
        endcase
    endfunction

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int thr_tab[4];
        int mags[7];
        thr_tab = '{49145, 40876, 32846, 24631};
        mags    = '{50000, 65536, 131071, 131072, 262143, 262144, -524288};

        // R1: reset state and hold between strobes
        do_reset();
        check("R1 reset left", vol_l, 160);
        check("R1 reset right", vol_r, 160);
        repeat (5) @(negedge clk);
        check("R1 hold", vol_l, 160);

        // R2: disabled limiter ignores loud samples
        lim_en = 1'b0;
        strobe(300000, -300000);
        check("R2 disabled left", vol_l, 160);
        check("R2 disabled right", vol_r, 160);
        lim_en = 1'b1;

        // R3/R9: threshold sweep with zero-cross gating off
        zc_off = 1'b1;
        for (int ts = 0; ts < 4; ts++) begin
            thr_sel = 2'(ts);
            step_sel = 2'd3;
            do_reset();
            strobe(thr_tab[ts], 0);
            check("R3 at threshold no change", vol_l, 160);
            strobe(0, -(thr_tab[ts] + 1));
            check("R3 R4 right over, left code", vol_l, 159);
            check("R9 step of one right code", vol_r, 159);
        end
        thr_sel = 2'd0;

        // R5/R8/R9: band and step sweep
        for (int z = 0; z < 2; z++) begin
            for (int ss = 0; ss < 4; ss++) begin
                for (int i = 0; i < 7; i++) begin
                    int m, b, exp_v;
                    m = mags[i];
                    b = band_of(abs_sat(m));
                    zc_off = z[0];
                    step_sel = 2'(ss);
                    do_reset();
                    strobe(m, 1000);
                    if (z == 1) exp_v = 159;
                    else if (b == 0) exp_v = 160;
                    else exp_v = 160 - step_of(ss, b);
                    check(z == 1 ? "R9 fixed step" : "R5 R8 band step left", vol_l, exp_v);
                    check("R4 R8 shared right", vol_r, exp_v);
                end
            end
        end

        // R10: saturation at zero
        zc_off = 1'b0;
        step_sel = 2'd2;
        do_reset();
        for (int i = 1; i <= 22; i++) begin
            int e;
            strobe(-400000, 0);
            e = 160 - 8 * i;
            if (e < 0) e = 0;
            check("R10 saturate", vol_l, e);
        end
        check("R10 floor right", vol_r, 0);

        // R6/R7/R11: zero-cross gating and timeout
        for (int t = 0; t < 4; t++) begin
            int tmo;
            tmo = 128 << t;
            tmo_sel = 2'(t);
            step_sel = 2'd2;
            do_reset();
            strobe(55000, 55000);
            check("R6 latched, left waits", vol_l, 160);
            check("R6 latched, right waits", vol_r, 160);
            strobe(-1000, 1000);
            check("R6 left zero crossing", vol_l, 158);
            check("R6 right no crossing", vol_r, 160);
            strobe(-1000, 55000);
            check("R6 extra over ignored", vol_r, 160);
            for (int k = 3; k < tmo; k++) strobe(-1000, 1000);
            check("R7 right before timeout", vol_r, 160);
            strobe(-1000, 1000);
            check("R7 right at timeout", vol_r, 158);
            check("R6 left unchanged", vol_l, 158);
            if (t == 0) begin
                strobe(-1000, 55000);
                check("R11 new latch waits", vol_r, 158);
                strobe(1000, -1000);
                check("R11 left next step", vol_l, 156);
                check("R11 right next step", vol_r, 156);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule